// File: doc/BRIEF.md
# Radix-3 Funnel Shifter

This block shifts a 16-bit word left by 0 to 8 positions. The positions that open up at the bottom are filled with the top bits of a second 16-bit word, which is what makes it a funnel shifter. The result is the upper half of the 32-bit pair {hi_word, lo_word} after a left shift by the requested amount. Shifting a stream of words through a pair of registers, or rotating (tie both words together), are the usual uses.

The shift is split into base-3 digits rather than binary ones. A first 3-to-1 selection level moves the pair by 0, 1 or 2 places, and a second one moves it by 0, 3 or 6. Nine positions therefore need two levels of logic instead of four. An amount above 8 is not a legal shift. For such an amount the block passes hi_word through unchanged and raises a flag. When the output register is enabled (the default), the result and the flag are captured on the rising clock edge.

Top module: `fsh_funnel_top`

## Requirements
- R1: While rst_n is low, result and amt_bad read 0 at the registered output.
- R2: For shamt in 0..8, result equals bits [31:16] of ({hi_word, lo_word} << shamt), with hi_word in bits [31:16] and lo_word in bits [15:0] of the pair.
- R3: For shamt of 0, result equals hi_word.
- R4: For shamt n in 1..8, result[n-1:0] equals lo_word[15:16-n], so bit 0 of result is lo_word[16-n].
- R5: For shamt in 9..15, result equals hi_word and amt_bad is 1. For shamt in 0..8, amt_bad is 0.
- R6: The shift is made in two cascaded 3-to-1 levels. The first level moves by shamt mod 3 and the second by 3 × (shamt div 3). For an illegal amount both levels select their zero-shift leg, and no level ever selects a fourth leg.
- R7: With the output register enabled, result and amt_bad reflect the inputs present at the previous rising edge. They do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| hi_word | input | 16 | Word whose bits move toward the top of the result |
| lo_word | input | 16 | Word whose top bits fill the vacated low positions |
| shamt | input | 4 | Left shift amount; 0..8 legal |
| result | output | 16 | Shifted result |
| amt_bad | output | 1 | High when shamt is above 8 |

## Verification
Both levels of selection are combinational, so every output is due exactly one rising edge after its inputs are applied. The bench drives inputs on the falling edge and reads result and amt_bad on the next falling edge, half a period after the capturing edge. For the latency requirement, it changes the inputs and reads the outputs a quarter period later, before any edge, and expects the old values. The reset state is read on falling edges while rst_n is held low.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

  // 3 raised to the k-th power
  function automatic int unsigned pow3(input int unsigned k);
    int unsigned p;
    p = 1;
    for (int unsigned i = 0; i < k; i++) p = p * 3;
    return p;
  endfunction

  // base-3 digit k of value a: the leg picked at stage k
  function automatic int unsigned digit3(input int unsigned a, input int unsigned k);
    return (a / pow3(k)) % 3;
  endfunction

  // smallest number of 3-way stages that covers 0..max_shift
  function automatic int unsigned stage_count(input int unsigned max_shift);
    int unsigned n;
    n = 1;
    while (pow3(n) <= max_shift) n++;
    return n;
  endfunction

endpackage

// File: rtl/fsh_mux3.sv
module fsh_mux3 #(
  parameter int unsigned N    = 32,
  parameter int unsigned STEP = 1
) (
  input  logic [N-1:0] din,
  input  logic [1:0]   sel,
  output logic [N-1:0] dout
);
  // one radix-3 level: shift by 0, STEP or 2*STEP
  always_comb begin
    case (sel)
      2'd1:    dout = din << STEP;
      2'd2:    dout = din << (2 * STEP);
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/fsh_funnel_top.sv
module fsh_funnel_top #(
  parameter int unsigned W         = 16,
  parameter int unsigned MAX_SHIFT = 8,
  parameter int unsigned SHW       = 4,
  parameter bit          OUT_REG   = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   hi_word,
  input  logic [W-1:0]   lo_word,
  input  logic [SHW-1:0] shamt,
  output logic [W-1:0]   result,
  output logic           amt_bad
);
  localparam int unsigned NST = fsh_pkg::stage_count(MAX_SHIFT);
  localparam int unsigned CW  = 2 * W;

  // named internal events used by the assertions
  logic           bad_comb;
  logic [1:0]     stage_sel [NST];
  logic [CW-1:0]  chain     [NST+1];
  logic [W-1:0]   res_comb;

  assign bad_comb = (shamt > SHW'(MAX_SHIFT));

  always_comb begin
    for (int unsigned k = 0; k < NST; k++) begin
      stage_sel[k] = bad_comb ? 2'd0 : 2'(fsh_pkg::digit3(int'(shamt), k));
    end
  end

  assign chain[0] = {hi_word, lo_word};

  for (genvar k = 0; k < NST; k++) begin : g_stage
    fsh_mux3 #(.N(CW), .STEP(fsh_pkg::pow3(k))) u_mux (
      .din  (chain[k]),
      .sel  (stage_sel[k]),
      .dout (chain[k+1])
    );
  end

  assign res_comb = chain[NST][CW-1 -: W];

  if (OUT_REG) begin : g_reg
    logic [W-1:0] res_q;
    logic         bad_q;
    logic         was_live;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_q    <= '0;
        bad_q    <= 1'b0;
        was_live <= 1'b0;
      end else begin
        res_q    <= res_comb;
        bad_q    <= bad_comb;
        was_live <= 1'b1;
      end
    end
    assign result  = res_q;
    assign amt_bad = bad_q;

    // R7: registered output is the previous cycle's combinational result
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      was_live |-> (res_q == $past(res_comb) && bad_q == $past(bad_comb)));
  end else begin : g_comb
    assign result  = res_comb;
    assign amt_bad = bad_comb;
  end

  // R6: no stage selects a fourth leg
  a_r6_legal_legs: assert property (@(posedge clk) disable iff (!rst_n)
    stage_sel[0] != 2'd3 && stage_sel[NST-1] != 2'd3);

  // R6: illegal amounts park every stage on its zero-shift leg
  a_r6_bad_parks: assert property (@(posedge clk) disable iff (!rst_n)
    bad_comb |-> (stage_sel[0] == 2'd0 && stage_sel[NST-1] == 2'd0));

  // R5: illegal amount passes hi_word through
  a_r5_bad_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (shamt > SHW'(MAX_SHIFT)) |-> (res_comb == hi_word));

  // R3: zero shift returns hi_word
  a_r3_zero_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (shamt == '0) |-> (res_comb == hi_word));

  // R4: lowest result bit comes from lo_word
  a_r4_low_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad_comb && shamt != '0) |-> (res_comb[0] == lo_word[W - int'(shamt)]));

endmodule

// File: tb/fsh_funnel_top_tb_top.sv
module fsh_funnel_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  // {hi, lo, amt}
  localparam logic [35:0] VECS [NVEC] = '{
    {16'hFFFF, 16'h0000, 4'd8},
    {16'h0000, 16'hFFFF, 4'd8},
    {16'h8001, 16'h8000, 4'd1},
    {16'h1234, 16'h5678, 4'd0},
    {16'h1234, 16'h5678, 4'd4},
    {16'hA5A5, 16'h5A5A, 4'd3},
    {16'hA5A5, 16'h5A5A, 4'd6},
    {16'h00FF, 16'hF00F, 4'd2},
    {16'hC3C3, 16'h3C3C, 4'd5},
    {16'h8000, 16'hFFFF, 4'd7},
    {16'hDEAD, 16'hBEEF, 4'd9},
    {16'h0F0F, 16'hF0F0, 4'd15}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hi_word = '0, lo_word = '0;
  logic [3:0]  shamt = '0;
  logic [15:0] result;
  logic        amt_bad;
  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsh_funnel_top dut_i (
    .clk(clk), .rst_n(rst_n), .hi_word(hi_word), .lo_word(lo_word),
    .shamt(shamt), .result(result), .amt_bad(amt_bad)
  );

  // bitwise reference, independent of the stage split
  function automatic logic [15:0] ref_res(input logic [15:0] h, input logic [15:0] l, input int a);
    logic [15:0] r;
    if (a > 8) return h;
    for (int i = 0; i < 16; i++) r[i] = (i >= a) ? h[i-a] : l[16+i-a];
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] exp_r, input logic exp_b);
    checks++;
    if (result !== exp_r || amt_bad !== exp_b) begin
      failures++;
      $display("FAIL %s: result=%h amt_bad=%b expected result=%h amt_bad=%b",
               req, result, amt_bad, exp_r, exp_b);
    end
  endtask

  // drive at falling edge, read at the next falling edge (one capture edge)
  task automatic apply(input logic [15:0] h, input logic [15:0] l, input logic [3:0] a);
    hi_word = h; lo_word = l; shamt = a;
    @(negedge clk);
  endtask

  function automatic string tag_for(input int a);
    if (a > 8)  return "R5";
    if (a == 0) return "R3";
    return "R2/R4";
  endfunction

  initial begin
    // R1: reset state with nonzero inputs
    hi_word = 16'hFFFF; lo_word = 16'hFFFF; shamt = 4'd12;
    @(negedge clk); @(negedge clk);
    check("R1", 16'h0000, 1'b0);

    rst_n = 1'b1;
    @(negedge clk);

    // table of vectors
    for (int v = 0; v < NVEC; v++) begin
      apply(VECS[v][35:20], VECS[v][19:4], VECS[v][3:0]);
      check(tag_for(int'(VECS[v][3:0])), ref_res(VECS[v][35:20], VECS[v][19:4], int'(VECS[v][3:0])),
            VECS[v][3:0] > 4'd8);
    end

    // R6 / R2 / R5: every amount with pseudo-random data
    for (int a = 0; a < 16; a++) begin
      for (int n = 0; n < 6; n++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        apply(lfsr[31:16], ~lfsr[15:0] ^ 16'h3C5A, 4'(a));
        check(a > 8 ? "R5" : "R6", ref_res(lfsr[31:16], ~lfsr[15:0] ^ 16'h3C5A, a), a > 8);
      end
    end

    // R4: single-bit fill pattern at each legal nonzero amount
    for (int a = 1; a <= 8; a++) begin
      apply(16'h0000, 16'h0001 << (16 - a), 4'(a));
      check("R4", 16'h0001, 1'b0);
    end

    // R7: output holds until the next edge
    apply(16'h1111, 16'h2222, 4'd0);
    hi_word = 16'h9999; shamt = 4'd11;
    #(CLK_PERIOD/4);
    check("R7", 16'h1111, 1'b0);
    @(negedge clk);
    check("R7", 16'h9999, 1'b1);

    // R1: reset re-applied mid-run
    rst_n = 1'b0;
    apply(16'h7777, 16'h8888, 4'd3);
    check("R1", 16'h0000, 1'b0);
    rst_n = 1'b1;
    apply(16'h7777, 16'h8888, 4'd3);
    check("R2", ref_res(16'h7777, 16'h8888, 3), 1'b0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule